// File: doc/BRIEF.md
# Serial Margining Divider Control

This block holds the feedback divider setting of a clock synthesizer that can be pushed slightly off its nominal frequency for margin testing. A host writes a 6-bit divider word over a three-wire serial link: a load strobe, a serial clock and a data line. The block publishes the divider value that the synthesizer loop should use. With the mode input low, that value is always the nominal divider of 50. With the mode input high, it is whatever word was last committed through the serial link. Each divider step moves the output frequency by 2%, so the usable window runs from 45 to 55.

All serial and mode inputs are treated as slow asynchronous levels. Each passes through a two-flop synchronizer into the system clock domain. Rising edges of the serial clock and falling edges of the strobe are found there by comparing the synchronized level with its value one cycle earlier. Bits collect in a shift register only while the strobe is high. The word passes to the control register only when the strobe drops. A word can be written while the mode input is low and then takes effect once the mode input goes high.

Top module: `mgn_div_ctrl`

## Requirements
- R1: After reset the committed word and the shift register both hold 50. `div_val` reads 50, `margin_on` is 0 and `in_range` is 1.
- R2: While `ser_ld` is high, each rising edge of `ser_clk` shifts `ser_dat` into the 6-bit shift register at bit 0, moving earlier bits toward bit 5. The first bit sent therefore ends up as the most significant bit, and only the last six bits of a longer burst are kept.
- R3: While `ser_ld` is low, `ser_clk` and `ser_dat` activity leaves the shift register unchanged. A later strobe pulse with no clock edges commits the old contents.
- R4: The committed word changes only on a high-to-low transition of `ser_ld`, which copies the shift register into it. While bits are still being shifted, `div_val` keeps its previous value.
- R5: With `mode_sel` low, `div_val` is 50 no matter what was committed.
- R6: With `mode_sel` high, `div_val` equals the committed word, and `margin_on` follows the synchronized `mode_sel`.
- R7: Words can be written and committed while `mode_sel` is low. They appear on `div_val` once `mode_sel` goes high.
- R8: `in_range` is 1 exactly when `div_val` lies between 45 and 55 inclusive.
- R9: When `mode_sel` goes from high to low, `div_val` returns to 50. The committed word is kept and appears again when `mode_sel` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, first bit is most significant |
| ser_ld | input | 1 | Load strobe: shift while high, commit on fall |
| mode_sel | input | 1 | 0 = nominal divider, 1 = margining divider |
| div_val | output | 6 | Active feedback divider value |
| margin_on | output | 1 | Synchronized margining mode indication |
| in_range | output | 1 | Active divider lies within 45..55 |

## Verification
A corrupted shift register stays hidden until the next strobe fall. The bench therefore commits after every write and reads the word on `div_val` in margining mode within a few system cycles. Words such as 32 and 1 would be swapped by a reversed bit order, and 63 and 0 catch stuck bits. A commit on the wrong strobe edge, or shifting while the strobe is low, shows up as a value change either before the strobe drops or after an unclocked strobe pulse. A committed word lost on a mode change shows up when margining is re-entered.

// File: rtl/mgn_div_pkg.sv
package mgn_div_pkg;

    // Width of the feedback divider word
    parameter int DIV_W = 6;

    typedef logic [DIV_W-1:0] div_t;

    // Register state of the serial shift/commit engine
    typedef struct packed {
        logic sclk_prev;   // synchronized serial clock, previous cycle
        logic ld_prev;     // synchronized strobe, previous cycle
        div_t sreg;        // shift register
        div_t ctrl;        // committed divider word
    } shift_state_t;

endpackage

// File: rtl/mgn_sync.sv
module mgn_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            always_comb stg_d[k] = d_in;
        end else begin : g_next
            always_comb stg_d[k] = stg_q[k-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[k] <= '0;
            else        stg_q[k] <= stg_d[k];
        end
    end

    assign d_out = stg_q[STAGES-1];

endmodule

// File: rtl/mgn_shift_ctl.sv
module mgn_shift_ctl
    import mgn_div_pkg::*;
#(
    parameter int NOMINAL = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic dat_s,
    input  logic ld_s,
    output div_t ctrl_val
);

    localparam div_t NOM_V = div_t'(NOMINAL);

    shift_state_t st_d, st_q;
    logic sclk_rise;
    logic ld_fall;

    always_comb begin
        st_d      = st_q;
        sclk_rise = sclk_s & ~st_q.sclk_prev;
        ld_fall   = ~ld_s & st_q.ld_prev;
        st_d.sclk_prev = sclk_s;
        st_d.ld_prev   = ld_s;
        if (ld_s && sclk_rise) begin
            st_d.sreg = {st_q.sreg[DIV_W-2:0], dat_s};
        end
        if (ld_fall) begin
            st_d.ctrl = st_q.sreg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk_prev <= 1'b0;
            st_q.ld_prev   <= 1'b0;
            st_q.sreg      <= NOM_V;
            st_q.ctrl      <= NOM_V;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_val = st_q.ctrl;

    // R2: a qualified clock edge shifts the data bit in at the bottom
    a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && ld_s) |=> st_q.sreg == {$past(st_q.sreg[DIV_W-2:0]), $past(dat_s)});

    // R3: strobe low freezes the shift register
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_s |=> $stable(st_q.sreg));

    // R4: strobe fall copies the shift register
    a_r4_commit: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fall |=> st_q.ctrl == $past(st_q.sreg));

    // R4: no strobe fall, no change of the committed word
    a_r4_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_fall |=> $stable(st_q.ctrl));

endmodule

// File: rtl/mgn_div_ctrl.sv
module mgn_div_ctrl
    import mgn_div_pkg::*;
#(
    parameter int NOMINAL  = 50,
    parameter int RANGE_LO = 45,
    parameter int RANGE_HI = 55,
    parameter int SYNC_N   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_ld,
    input  logic             mode_sel,
    output logic [DIV_W-1:0] div_val,
    output logic             margin_on,
    output logic             in_range
);

    localparam div_t NOM_V = div_t'(NOMINAL);
    localparam div_t LO_V  = div_t'(RANGE_LO);
    localparam div_t HI_V  = div_t'(RANGE_HI);

    logic [3:0] raw_in;
    logic [3:0] syn_out;
    div_t       ctrl_val;
    div_t       active;

    assign raw_in = {mode_sel, ser_ld, ser_clk, ser_dat};

    mgn_sync #(.WIDTH(4), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .d_out (syn_out)
    );

    mgn_shift_ctl #(.NOMINAL(NOMINAL)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (syn_out[1]),
        .dat_s    (syn_out[0]),
        .ld_s     (syn_out[2]),
        .ctrl_val (ctrl_val)
    );

    always_comb begin
        active    = syn_out[3] ? ctrl_val : NOM_V;
        div_val   = active;
        margin_on = syn_out[3];
        in_range  = (active >= LO_V) && (active <= HI_V);
    end

    // R5: default mode always shows the nominal divider
    a_r5_default_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        !margin_on |-> div_val == NOM_V);

    // R9: leaving margining restores nominal
    a_r9_restore: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(margin_on) |-> div_val == NOM_V);

endmodule

// File: tb/mgn_div_ctrl_test.sv
module mgn_div_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       ser_ld = 1'b0;
    logic       mode_sel = 1'b0;
    logic [5:0] div_val;
    logic       margin_on;
    logic       in_range;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [5:0] dv;
        logic       mo;
        logic       rg;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    mgn_div_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_dat   (ser_dat),
        .ser_ld    (ser_ld),
        .mode_sel  (mode_sel),
        .div_val   (div_val),
        .margin_on (margin_on),
        .in_range  (in_range)
    );

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected flag from the requirement window 45..55 (R8)
    function automatic logic rng_of(input logic [5:0] v);
        return (v >= 6'd45) && (v <= 6'd55);
    endfunction

    task automatic expect_now(input logic [5:0] dv, input logic mo, input string tag);
        exp_t e;
        hold(6);
        e.dv = dv; e.mo = mo; e.rg = rng_of(dv); e.tag = tag;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
        hold(1);
    endtask

    // Shift nbits of val (first bit = bit nbits-1), optionally drop the strobe
    task automatic shift_word(input logic [15:0] val, input int nbits, input bit commit);
        ser_ld = 1'b1;
        hold(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_dat = val[i];
            hold(4);
            ser_clk = 1'b1;
            hold(4);
            ser_clk = 1'b0;
            hold(4);
        end
        if (commit) begin
            ser_ld = 1'b0;
            hold(4);
        end
    endtask

    // Monitor: compare outputs against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (div_val !== e.dv || margin_on !== e.mo || in_range !== e.rg) begin
                    errors++;
                    $display("FAIL %s: got div=%0d mode=%0b rng=%0b expected div=%0d mode=%0b rng=%0b",
                             e.tag, div_val, margin_on, in_range, e.dv, e.mo, e.rg);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        hold(4);
        rst_n = 1'b1;
        // R1 reset state
        expect_now(6'd50, 1'b0, "R1 reset");

        // R7 / R5: preload 47 in default mode
        shift_word(16'd47, 6, 1'b1);
        expect_now(6'd50, 1'b0, "R5 default ignores committed word");
        mode_sel = 1'b1;
        expect_now(6'd47, 1'b1, "R7 preload visible in margining");

        // R4: shifting without commit keeps old value
        shift_word(16'd53, 6, 1'b0);
        expect_now(6'd47, 1'b1, "R4 no change before strobe fall");
        ser_ld = 1'b0;
        expect_now(6'd53, 1'b1, "R4 commit on strobe fall");

        // R3: activity with strobe low is ignored
        for (int i = 0; i < 8; i++) begin
            ser_dat = 1'b1; hold(3);
            ser_clk = 1'b1; hold(3);
            ser_clk = 1'b0; hold(3);
        end
        ser_dat = 1'b0;
        expect_now(6'd53, 1'b1, "R3 idle activity no output change");
        ser_ld = 1'b1; hold(6);
        ser_ld = 1'b0; hold(4);
        expect_now(6'd53, 1'b1, "R3 shift register unchanged");

        // R2: bit order and long bursts
        shift_word(16'd32, 6, 1'b1);
        expect_now(6'd32, 1'b1, "R2 first bit is MSB");
        shift_word({4'd0, 6'b111111, 6'b110100}, 12, 1'b1);
        expect_now(6'd52, 1'b1, "R2 last six bits kept");

        // R8 range boundaries (R6 programmed value visible)
        shift_word(16'd45, 6, 1'b1);
        expect_now(6'd45, 1'b1, "R8 low bound");
        shift_word(16'd55, 6, 1'b1);
        expect_now(6'd55, 1'b1, "R8 high bound");
        shift_word(16'd44, 6, 1'b1);
        expect_now(6'd44, 1'b1, "R8 below range");
        shift_word(16'd56, 6, 1'b1);
        expect_now(6'd56, 1'b1, "R8 above range");
        shift_word(16'd63, 6, 1'b1);
        expect_now(6'd63, 1'b1, "R6 all ones");
        shift_word(16'd0, 6, 1'b1);
        expect_now(6'd0, 1'b1, "R6 all zeros");

        // R9: return to default and back
        shift_word(16'd51, 6, 1'b1);
        expect_now(6'd51, 1'b1, "R6 programmed 51");
        mode_sel = 1'b0;
        expect_now(6'd50, 1'b0, "R9 nominal restored");
        mode_sel = 1'b1;
        expect_now(6'd51, 1'b1, "R9 committed word retained");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule